// File: doc/BRIEF.md
# SAR ADC Conversion Sequencer

This block is the digital controller of a 10-bit successive-approximation converter. It times each conversion step with a conversion clock. That clock is either the system clock divided by a selectable power of two (2 to 64) or the rising edges of a free-running internal RC oscillator input. The analog comparator, the DAC and the input multiplexer sit outside the block.

Software requests a conversion with a one-cycle `go_set` pulse while the block is enabled. The block then runs eleven conversion periods:

- **First period:** the holding capacitor is disconnected.
- **Remaining ten periods:** one per result bit, resolved MSB first. Each period tries one bit on the DAC code and keeps or drops it from the comparator output.
- **Commit cycle:** one system-clock cycle after the last period, the result is stored, busy drops, the sample switch closes again and a sticky completion flag rises.

While the device sleeps, only the RC clock may run conversions.

Top module: `sar_seq`

## Requirements
- R1: With `clk_sel` set to 000, 100, 001, 101, 010 or 110, one conversion period lasts 2, 4, 8, 16, 32 or 64 system clocks respectively. The divider restarts at the start edge, so `flag` is first seen high exactly 11*N+1 rising edges after the edge that accepts the request.
- R2: When `clk_sel[1:0]` is 11, each conversion period ends on a rising edge of `rc_clk`. That edge is seen through a two-stage synchroniser. A conversion on this source completes with a correct result.
- R3: While `asleep` is high, a divided-clock selection neither starts a conversion nor keeps one running: a running one aborts on the next edge. The RC selection converts normally while `asleep` is high.
- R4: A `go_set` pulse starts a conversion only when `en` is high and `busy` is low; `busy` is high after the accepting edge. A `go_set` pulse with `en` low leaves `busy` low.
- R5: From the accepting edge until the commit edge, `sample_on` is low (capacitor disconnected). During the first period `dac_code` is 0.
- R6: Each bit period sets the trial bit in `dac_code`. The bit is kept when `cmp` is 1 (input at or above the trial code) on the last system clock of the period, and cleared otherwise. With an ideal comparator, `result` equals the input code.
- R7: One edge after the last period ends, `result` takes the resolved code, `busy` falls, `sample_on` rises and `flag` is set, all on the same edge.
- R8: A `go_set` pulse while `busy` is high has no effect on timing or result.
- R9: Driving `en` low during a conversion clears `busy` on the next edge, leaves `result` unchanged and does not set `flag`.
- R10: `flag` stays high until a `flag_clr` pulse. A completion in the same cycle as `flag_clr` leaves it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Converter enable |
| go_set | input | 1 | One-cycle conversion request |
| flag_clr | input | 1 | One-cycle flag clear |
| clk_sel | input | 3 | Conversion clock select |
| cmp | input | 1 | Comparator: 1 when input is at or above the DAC code |
| rc_clk | input | 1 | Internal RC oscillator |
| asleep | input | 1 | Device sleep indication |
| busy | output | 1 | Conversion in progress (GO status) |
| sample_on | output | 1 | Holding capacitor connected to input |
| dac_code | output | 10 | Trial code to the DAC |
| result | output | 10 | Last committed result |
| flag | output | 1 | Sticky completion flag |

## Verification
A wrong period count or a wrong divider limit moves the completion flag by whole periods, so it shows as an exact edge-count mismatch as soon as the first conversion ends. A wrong bit decision or a wrong trial-bit position shows at the commit edge as a result that differs from the input code; several input codes are used so that every bit position is exercised. Wrong abort or sleep gating shows on the very next edge as `busy` staying high, or later as a flag or result change that should not have happened.

// File: rtl/sar_seq.sv
module sar_seq #(
  parameter int NBITS = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             go_set,
  input  logic             flag_clr,
  input  logic [2:0]       clk_sel,
  input  logic             cmp,
  input  logic             rc_clk,
  input  logic             asleep,
  output logic             busy,
  output logic             sample_on,
  output logic [NBITS-1:0] dac_code,
  output logic [NBITS-1:0] result,
  output logic             flag
);
  localparam int PW = $clog2(NBITS + 2);
  localparam int DW = 6;

  logic          use_rc, rc_edge, tick, halt, start;
  logic [2:0]    rc_sh;
  logic [2:0]    shamt;
  logic [DW:0]   span;
  logic [DW-1:0] lim, div;
  logic [PW-1:0] p;

  assign use_rc  = &clk_sel[1:0];
  assign shamt   = {clk_sel[1:0], 1'b0} + {2'b00, clk_sel[2]} + 3'd1;
  assign span    = (DW+1)'(1) << shamt;
  assign lim     = DW'(span - (DW+1)'(1));
  assign rc_edge = rc_sh[1] & ~rc_sh[2];
  assign tick    = use_rc ? rc_edge : (div >= lim);
  assign halt    = !en || (asleep && !use_rc);
  assign start   = go_set && !halt;

  assign sample_on = ~busy;

  always_ff @(posedge clk) begin
    if (!rst_n) rc_sh <= '0;
    else        rc_sh <= {rc_sh[1:0], rc_clk};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      flag     <= 1'b0;
      p        <= '0;
      div      <= '0;
      dac_code <= '0;
      result   <= '0;
    end else begin
      if (flag_clr) flag <= 1'b0;
      if (!busy) begin
        busy     <= start;
        p        <= '0;
        div      <= '0;
        dac_code <= '0;
      end else if (halt) begin
        busy <= 1'b0;
        p    <= '0;
      end else if (p == PW'(NBITS + 1)) begin
        busy   <= 1'b0;
        result <= dac_code;
        flag   <= 1'b1;
        p      <= '0;
      end else begin
        div <= tick ? '0 : div + 1'b1;
        if (tick) begin
          p <= p + 1'b1;
          for (int i = 0; i < NBITS; i++) begin
            if (p == PW'(NBITS - i))     dac_code[i] <= cmp;
            if (p == PW'(NBITS - 1 - i)) dac_code[i] <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk #(
  parameter int NBITS = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             go_set,
  input logic             flag_clr,
  input logic [2:0]       clk_sel,
  input logic             asleep,
  input logic             busy,
  input logic [NBITS-1:0] result,
  input logic             flag
);
  // R7
  flag_rise_at_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $fell(busy));

  // R7
  result_only_at_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(result) |-> $fell(busy));

  // R9
  abort_on_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !en) |=> (!busy && $stable(result)));

  // R3
  sleep_blocks_divider_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (asleep && clk_sel[1:0] != 2'b11) |=> !busy);

  // R4
  start_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !en) |=> !busy);

  // R10
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !flag_clr) |=> flag);

  // R4
  request_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !go_set) |=> !busy);
endmodule

bind sar_seq sar_seq_chk #(.NBITS(NBITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .go_set(go_set), .flag_clr(flag_clr),
  .clk_sel(clk_sel), .asleep(asleep), .busy(busy), .result(result), .flag(flag)
);

// File: tb/sar_seq_test.sv
module sar_seq_test;
  logic       clk = 0, rst_n = 0, en = 0, go_set = 0, flag_clr = 0;
  logic       rc_clk = 0, asleep = 0;
  logic [2:0] clk_sel = 3'b000;
  logic [9:0] vin = '0;
  logic       cmp, busy, sample_on, flag;
  logic [9:0] dac_code, result;
  int         errs = 0, checks = 0, cyc = 0;

  sar_seq uut (
    .clk(clk), .rst_n(rst_n), .en(en), .go_set(go_set), .flag_clr(flag_clr),
    .clk_sel(clk_sel), .cmp(cmp), .rc_clk(rc_clk), .asleep(asleep),
    .busy(busy), .sample_on(sample_on), .dac_code(dac_code), .result(result), .flag(flag)
  );

  assign cmp = (vin >= dac_code);

  always #4 clk = ~clk;
  always #160 rc_clk = ~rc_clk;

  // {clk_sel, input code, period in system clocks}
  localparam logic [19:0] VEC [6] = '{
    {3'b000, 10'h3FF, 7'd2},
    {3'b100, 10'h000, 7'd4},
    {3'b001, 10'h200, 7'd8},
    {3'b101, 10'h1FF, 7'd16},
    {3'b010, 10'h2AA, 7'd32},
    {3'b110, 10'h155, 7'd64}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic convert(input logic [2:0] sel, input logic [9:0] v,
                         input int lo, input int hi, input bit mid_go);
    int  n;
    bit  opened;
    @(negedge clk); clk_sel = sel; vin = v; en = 1; flag_clr = 1;
    @(negedge clk); flag_clr = 0; go_set = 1;
    @(negedge clk); go_set = 0;
    chk(busy == 1, "R4 busy after request", busy, 1);
    chk(sample_on == 0 && dac_code == 0, "R5 first period", {sample_on, dac_code}, 0);
    n = 0; opened = 0;
    while (!flag && n < 3000) begin
      @(negedge clk); n++;
      go_set = (mid_go && n == 5);
      if (!flag && sample_on) opened = 1;
    end
    go_set = 0;
    chk(n >= lo && n <= hi, "R1/R2 edges to flag", n, lo);
    chk(result == v, "R6 resolved code", result, v);
    chk(busy == 0 && sample_on == 1, "R7 commit state", {busy, sample_on}, 1);
    chk(!opened, "R5 capacitor held open", opened, 0);
  endtask

  initial begin
    forever begin
      @(posedge clk); cyc++;
      if (cyc > 150000) begin
        errs++; checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
      end
    end
  end

  initial begin
    logic [9:0] kept;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !flag && result == 0 && sample_on && dac_code == 0, "reset state",
        {busy, flag, result}, 0);

    for (int i = 0; i < 6; i++)
      convert(VEC[i][19:17], VEC[i][16:7], 11*VEC[i][6:0]+1, 11*VEC[i][6:0]+1, 0);

    // R10 flag stays until cleared
    repeat (30) @(negedge clk);
    chk(flag == 1, "R10 flag sticky", flag, 1);
    flag_clr = 1; @(negedge clk); flag_clr = 0;
    chk(flag == 0, "R10 flag cleared", flag, 0);

    // R8 second request while busy
    convert(3'b000, 10'h0F3, 23, 23, 1);

    // R4 request with enable low
    en = 0; go_set = 1; @(negedge clk); go_set = 0;
    repeat (3) @(negedge clk);
    chk(busy == 0, "R4 ignored when disabled", busy, 0);

    // R9 abort via enable
    flag_clr = 1; @(negedge clk); flag_clr = 0;
    kept = result;
    clk_sel = 3'b100; vin = 10'h301; en = 1; go_set = 1;
    @(negedge clk); go_set = 0;
    repeat (10) @(negedge clk);
    en = 0; @(negedge clk);
    chk(busy == 0, "R9 abort clears busy", busy, 0);
    repeat (60) @(negedge clk);
    chk(flag == 0 && result == kept, "R9 no flag, result kept", result, kept);

    // R3 sleep blocks divided clock at start
    asleep = 1; en = 1; clk_sel = 3'b000; go_set = 1;
    @(negedge clk); go_set = 0; @(negedge clk);
    chk(busy == 0, "R3 sleep blocks start", busy, 0);

    // R3 sleep aborts running divided-clock conversion
    asleep = 0; clk_sel = 3'b001; go_set = 1;
    @(negedge clk); go_set = 0;
    repeat (20) @(negedge clk);
    chk(busy == 1, "R3 running before sleep", busy, 1);
    asleep = 1; @(negedge clk);
    chk(busy == 0, "R3 sleep aborts", busy, 0);
    chk(flag == 0, "R3 no flag on abort", flag, 0);

    // R2 RC clock, in sleep and awake
    convert(3'b111, 10'h1C7, 400, 450, 0);
    asleep = 0;
    convert(3'b011, 10'h238, 400, 450, 0);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule